// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Divider

This block divides a fast input clock by a programmable integer. It does this with a dual-modulus prescaler and two down counters. The prescaler is modelled here as a synchronous submodule. It emits a one-clock tick at the end of every period, and each period is N+1 or N input clocks long. A modulus-control output, `mod_o`, selects between the two. The program counter counts P prescaler periods in each division cycle. The swallow counter counts the first S of those periods. During the first S periods the prescaler runs in its long (N+1) mode. After that it runs in its short (N) mode until the program counter terminates. The whole division cycle therefore lasts N·P + S input clocks.

A single band select picks the prescaler pair. Band 0 divides by 32/33 and band 1 by 47/48, so the same pair of counters serves two frequency bands. The programmed P, S and band are sampled only when a division cycle ends. At that point `ld_o` pulses, both counters reload, and the modulus control returns to the long mode. The swallow counter holds its value whenever the short mode is active.

The controller is a three-state machine:
- LOAD: entered on reset; takes the first values and holds the prescaler.
- SWALLOW: `mod_o`=0.
- STEADY: `mod_o`=1.

The transitions are:
- LOAD → SWALLOW or STEADY, the choice depending on whether the effective S is zero.
- SWALLOW → STEADY on the tick that exhausts the swallow counter.
- SWALLOW or STEADY → SWALLOW or STEADY on the final program tick (reload). The reload takes priority over the swallow exit when both fall on the same tick.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `mod_o`, `ld_o` and `tick_o` are all 0.
- R2: While `mod_o` is 1, each prescaler period lasts N input clocks, where N is 32 when the latched band is 0 and 47 when it is 1. A division cycle spends N·(P−S) input clocks with `mod_o` high.
- R3: The spacing between consecutive `ld_o` pulses is N·P + S input clocks, for P and S inside their bands (low band: P 75..78, S 0..31; high band: P 105..122, S 0..47).
- R4: Each division cycle begins with `mod_o` low for exactly (N+1)·S input clocks. When S is 0, `mod_o` is high for the whole cycle.
- R5: Once `mod_o` rises within a division cycle, it stays high until the reload. While it is high, the swallow count is frozen.
- R6: `p_prog`, `s_prog` and `band_sel` are sampled only at a reload. A change in the middle of a cycle leaves that cycle's length unchanged.
- R7: `ld_o` is a single-clock pulse. It appears in the first clock of each division cycle, one clock after the final prescaler tick.
- R8: An S larger than the effective P is treated as equal to it. A P of 0 is treated as 1.
- R9: When S equals P, every period of the cycle is long. The cycle lasts (N+1)·P clocks and the reload takes priority over the swallow exit.
- R10: `band_o` changes only together with an `ld_o` pulse. It holds the band used by the current cycle.
- R11: `tick_o` is a single-clock pulse. It occurs exactly P times per division cycle, with P the effective value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_prog | input | 7 | Programmed program-counter value P |
| s_prog | input | 6 | Programmed swallow value S |
| band_sel | input | 1 | Band select: 0 = 32/33 pair, 1 = 47/48 pair |
| mod_o | output | 1 | Modulus control: 0 = N+1 mode, 1 = N mode |
| band_o | output | 1 | Band latched at the last reload, fed to the prescaler |
| tick_o | output | 1 | Prescaler output, one pulse per prescaler period |
| ld_o | output | 1 | Reload pulse, once per division cycle |

## Verification
Two events can fall on the same prescaler tick: the swallow counter running out and the program counter reaching its terminal count. Programming S equal to P makes them coincide, and so does an oversized S that is clamped down to P. The bench then expects a cycle made entirely of long periods and an immediate reload, with `mod_o` never rising. The second same-cycle case is a reload meeting fresh input values. The bench changes P, S and band in the middle of a cycle, and also right after a reload. It then judges every cycle's length, its count of low and high modulus clocks, its tick count and its band against the values that were in force at that cycle's reload.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_STEADY  = 2'd2
    } psd_state_e;

    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int unsigned N_LO = 32,
    parameter int unsigned N_HI = 47,
    localparam int unsigned CW  = $clog2(N_HI + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic band,
    input  logic mode_short,
    output logic tick
);

    logic [CW-1:0] phase;
    logic [CW-1:0] last;

    // terminal phase: period length is last + 1
    always_comb begin
        unique case ({band, mode_short})
            2'b00:   last = CW'(N_LO);
            2'b01:   last = CW'(N_LO - 1);
            2'b10:   last = CW'(N_HI);
            default: last = CW'(N_HI - 1);
        endcase
    end

    assign tick = !hold && (phase == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (hold || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/psd_downcnt.sv
module psd_downcnt #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         at_one
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (en) begin
            count <= count - 1'b1;
        end
    end

    assign at_one = (count == W'(1));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int unsigned P_W  = 7,
    parameter int unsigned S_W  = 6,
    parameter int unsigned N_LO = 32,
    parameter int unsigned N_HI = 47
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [P_W-1:0] p_prog,
    input  logic [S_W-1:0] s_prog,
    input  logic           band_sel,
    output logic           mod_o,
    output logic           band_o,
    output logic           tick_o,
    output logic           ld_o
);

    localparam int unsigned XW = larger(P_W, S_W);

    psd_state_e state, state_nx;

    logic           tick;
    logic           reload;
    logic           p_one, s_one;
    logic [P_W-1:0] p_val;
    logic [S_W-1:0] s_val;
    logic [P_W-1:0] p_eff;
    logic [XW-1:0]  p_ext, s_ext, s_min;
    logic [S_W-1:0] s_eff;
    logic           band_q, ld_q;

    // effective programmed values: P of zero acts as one, S no larger than P
    always_comb begin
        p_eff = (p_prog == '0) ? P_W'(1) : p_prog;
        p_ext = XW'(p_eff);
        s_ext = XW'(s_prog);
        s_min = (s_ext > p_ext) ? p_ext : s_ext;
        s_eff = s_min[S_W-1:0];
    end

    assign reload = (state == ST_LOAD) || (tick && p_one);

    // state register
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (reload) begin
            state_nx = (s_eff == '0) ? ST_STEADY : ST_SWALLOW;
        end else begin
            unique case (state)
                ST_SWALLOW: if (tick && s_one) state_nx = ST_STEADY;
                ST_STEADY:  state_nx = ST_STEADY;
                default:    state_nx = ST_LOAD;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        unique case (state)
            ST_STEADY: mod_o = 1'b1;
            default:   mod_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= 1'b0;
            ld_q   <= 1'b0;
        end else begin
            ld_q <= reload;
            if (reload) band_q <= band_sel;
        end
    end

    psd_prescaler #(.N_LO(N_LO), .N_HI(N_HI)) u_pre (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .hold       (state == ST_LOAD),
        .band       (band_q),
        .mode_short (mod_o),
        .tick       (tick)
    );

    psd_downcnt #(.W(P_W)) u_pcnt (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (p_eff),
        .en       (tick && !reload),
        .count    (p_val),
        .at_one   (p_one)
    );

    psd_downcnt #(.W(S_W)) u_scnt (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (s_eff),
        .en       (tick && !reload && (state == ST_SWALLOW)),
        .count    (s_val),
        .at_one   (s_one)
    );

    assign band_o = band_q;
    assign tick_o = tick;
    assign ld_o   = ld_q;

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int unsigned S_W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mod_o,
    input logic           ld_o,
    input logic           tick_o,
    input logic           band_o,
    input logic           p_one,
    input logic [S_W-1:0] s_val
);

    assert_ld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_o |=> !ld_o);

    assert_tick_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_mod_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_o) |-> ld_o);

    assert_s_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_o && !(tick_o && p_one)) |=> $stable(s_val));

    assert_band_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_o) |-> ld_o);

endmodule

bind pulse_swallow_div psd_checker #(.S_W(S_W)) u_chk (
    .clk    (clk_in),
    .rst_n  (rst_n),
    .mod_o  (mod_o),
    .ld_o   (ld_o),
    .tick_o (tick_o),
    .band_o (band_o),
    .p_one  (p_one),
    .s_val  (s_val)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;

    localparam int P_W  = 7;
    localparam int S_W  = 6;
    localparam int N_LO = 32;
    localparam int N_HI = 47;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [P_W-1:0] p_prog;
    logic [S_W-1:0] s_prog;
    logic           band_sel;
    logic           mod_o, band_o, tick_o, ld_o;

    always #2.5 clk = ~clk;

    pulse_swallow_div u0 (
        .clk_in   (clk),
        .rst_n    (rst_n),
        .p_prog   (p_prog),
        .s_prog   (s_prog),
        .band_sel (band_sel),
        .mod_o    (mod_o),
        .band_o   (band_o),
        .tick_o   (tick_o),
        .ld_o     (ld_o)
    );

    typedef struct {
        int    total;
        int    low_clk;
        int    high_clk;
        int    ticks;
        logic  band;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cur_p, cur_s;
    logic cur_b;
    string cur_tag;

    function automatic exp_t model(int p, int s, logic b, string tag);
        exp_t e;
        int n  = b ? N_HI : N_LO;
        int pe = (p == 0) ? 1 : p;
        int se = (s > pe) ? pe : s;
        e.total    = n * pe + se;
        e.low_clk  = (n + 1) * se;
        e.high_clk = n * (pe - se);
        e.ticks    = pe;
        e.band     = b;
        e.tag      = tag;
        return e;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: measures each window between reload pulses
    int   win = 0, lwin = 0, twin = 0, falls = 0;
    logic wband = 1'b0;
    logic prev_ld = 1'b0, prev_mod = 1'b0;
    exp_t got;

    always @(negedge clk) begin
        if (rst_n) begin
            win++;
            if (prev_mod && !mod_o && !ld_o) falls++;
            if (ld_o) begin
                check("R7 ld width", int'(prev_ld), 0);
                if (q.size() > 0) begin
                    got = q.pop_front();
                    check({got.tag, " total ratio"}, win, got.total);
                    check("R4 low-modulus clocks", lwin, got.low_clk);
                    check("R2 high-modulus clocks", win - lwin, got.high_clk);
                    check("R11 ticks per cycle", twin, got.ticks);
                    check("R10 band", int'(wband), int'(got.band));
                    check("R5 modulus falls", falls, 0);
                end
                win = 0; lwin = 0; twin = 0; falls = 0;
                wband = band_o;
            end
            if (!mod_o) lwin++;
            if (tick_o) twin++;
            prev_ld  = ld_o;
            prev_mod = mod_o;
        end
    end

    task automatic wait_ld();
        do @(negedge clk); while (!ld_o);
    endtask

    // driver: after a reload, queue the cycle just begun, then program the next
    task automatic run_case(int p, int s, logic b, string tag, int delay);
        string t;
        wait_ld();
        repeat (delay) @(posedge clk);
        @(posedge clk);
        #1;
        t = (delay > 0) ? "R6" : cur_tag;
        q.push_back(model(cur_p, cur_s, cur_b, t));
        p_prog   = P_W'(p);
        s_prog   = S_W'(s);
        band_sel = b;
        cur_p = p; cur_s = s; cur_b = b; cur_tag = tag;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        p_prog = 7'd77; s_prog = 6'd5; band_sel = 1'b0;
        cur_p = 77; cur_s = 5; cur_b = 1'b0; cur_tag = "R3";
        repeat (4) @(posedge clk);
        #1;
        check("R1 mod in reset", int'(mod_o), 0);
        check("R1 ld in reset", int'(ld_o), 0);
        check("R1 tick in reset", int'(tick_o), 0);
        rst_n = 1'b1;

        run_case(75,  0, 1'b0, "R3", 0);
        run_case(78, 31, 1'b0, "R3", 0);
        run_case(76, 10, 1'b1, "R3", 0);
        run_case(105, 47, 1'b1, "R3", 0);
        run_case(122,  0, 1'b1, "R3", 0);
        run_case(110, 20, 1'b0, "R3", 0);
        run_case(20,  20, 1'b0, "R3", 0);
        run_case(10,  40, 1'b1, "R9", 0);
        run_case(0,    0, 1'b0, "R8", 0);
        run_case(0,    5, 1'b1, "R8", 0);
        run_case(115, 47, 1'b1, "R8", 0);
        run_case(77,   3, 1'b0, "R3", 1500);
        run_case(1,    1, 1'b1, "R3", 0);
        run_case(1,    1, 1'b1, "R9", 0);
        wait_ld();
        @(posedge clk);
        #1;
        check("R3 queue drained", q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule